// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block gathers up to 32 interrupt sources into one interrupt request for a processor. Each source owns one fixed bit in a pending register and one bit in a mask register. A source that fires sets its pending bit whatever its mask says. The request output is raised while any bit is both pending and enabled. Alongside the request, the block reports the number of the highest-priority active source. Bit 0 ranks highest.

Software reaches both registers over a small register bus. A pending bit is cleared by writing 1 to it, and a 0 in the write data leaves that bit alone. Some sources are summaries of an event register outside this block. For those sources, a per-source flag marks the pending bit as event-backed. Such a bit copies its source's event-summary input every cycle and ignores software writes. Software clears it by clearing the event bits that drive the summary.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending register and the mask register both read as zero, and `irq_req` is 0.
- R2: A pulse on `src_fire[i]` for a source that is not event-backed sets pending bit i on the next clock edge, whatever mask bit i holds.
- R3: A write to address 0 clears every pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When a source fires in the same cycle as a clear of its own bit, the bit stays set.
- R5: A pending source whose mask bit is 0 does not raise `irq_req`.
- R6: `irq_req` is the OR over all bits of pending AND mask. It therefore falls in the cycle after a mask write that disables the only active source. It rises again once the mask bit is set while the bit is still pending.
- R7: `irq_idx` gives the lowest-numbered bit that is both pending and enabled. It reads 0 when `irq_req` is 0.
- R8: For a source with `evt_backed[i]`=1, pending bit i equals the value `evt_summary[i]` had at the previous clock edge. `src_fire[i]` and pending-register writes have no effect on that bit.
- R9: A write to address 1 loads the mask register, and the mask can be read back at address 1 at any time.
- R10: Address map: 0 holds pending (write 1 to clear) and 1 holds mask. Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational on `addr` |
| src_fire | input | 32 | One event pulse per source |
| evt_backed | input | 32 | Marks a source's pending bit as event-backed |
| evt_summary | input | 32 | OR of each event-backed source's unmasked event bits |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 5 | Number of the highest-priority active source |

## Verification
A pending bit that is wrongly held or lost appears at the read port on the edge after the event that should have changed it. If that source is enabled, the error also reaches `irq_req` and `irq_idx` in the same cycle.

A faulty priority encoder shows only when two or more enabled bits are pending at once. The stimulus therefore keeps several sources active together.

A fault in the event-backed path shows as a bit that outlives its summary input by more than one edge. It also shows as a bit that reacts to a clear write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_fire,
  input  logic [N-1:0] evt_backed,
  input  logic [N-1:0] evt_summary,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                   pend_q[i] <= 1'b0;
      else if (evt_backed[i])       pend_q[i] <= evt_summary[i];
      else if (src_fire[i])         pend_q[i] <= 1'b1;   // new event beats a clear
      else if (clr_en && clr_bits[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  active,
  output logic          any,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  assign any = |active;
  assign idx = lowest_set(active);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      rd_data,
  input  logic [N-1:0]      src_fire,
  input  logic [N-1:0]      evt_backed,
  input  logic [N-1:0]      evt_summary,
  output logic              irq_req,
  output logic [IW-1:0]     irq_idx
);
  logic         reg_wr_pend;
  logic         reg_wr_mask;
  logic [N-1:0] pend_vec;
  logic [N-1:0] mask_vec;
  logic [N-1:0] active_vec;

  assign reg_wr_pend = wr_en && (addr == REG_PEND);
  assign reg_wr_mask = wr_en && (addr == REG_MASK);

  irq_pend_bank #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_fire(src_fire), .evt_backed(evt_backed),
    .evt_summary(evt_summary), .clr_en(reg_wr_pend), .clr_bits(wr_data),
    .pend_q(pend_vec)
  );

  irq_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_mask), .wr_data(wr_data),
    .mask_q(mask_vec)
  );

  assign active_vec = pend_vec & mask_vec;

  irq_prio_enc #(.N(N), .IW(IW)) u_enc (
    .active(active_vec), .any(irq_req), .idx(irq_idx)
  );

  always_comb begin
    case (addr)
      REG_PEND: rd_data = pend_vec;
      REG_MASK: rd_data = mask_vec;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  wr_data,
  input logic          reg_wr_pend,
  input logic          reg_wr_mask,
  input logic [N-1:0]  src_fire,
  input logic [N-1:0]  evt_backed,
  input logic [N-1:0]  evt_summary,
  input logic [N-1:0]  pend_vec,
  input logic [N-1:0]  mask_vec,
  input logic          irq_req,
  input logic [IW-1:0] irq_idx
);
  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(src_fire & ~evt_backed) & ~pend_vec) == '0)); // R2

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr_pend) |->
      ((pend_vec & $past(wr_data & ~src_fire & ~evt_backed)) == '0)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & mask_vec) == '0) |-> !irq_req); // R5

  AST_IDX_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_vec[irq_idx] && mask_vec[irq_idx])); // R7

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend_vec & mask_vec & ((N'(1) << irq_idx) - N'(1))) == '0)); // R7

  AST_EVT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pend_vec ^ $past(evt_summary)) & $past(evt_backed)) == '0)); // R8

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr_mask) |-> (mask_vec == $past(wr_data))); // R9
endmodule

bind irq_aggregator irq_agg_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .reg_wr_pend(reg_wr_pend),
  .reg_wr_mask(reg_wr_mask), .src_fire(src_fire), .evt_backed(evt_backed),
  .evt_summary(evt_summary), .pend_vec(pend_vec), .mask_vec(mask_vec),
  .irq_req(irq_req), .irq_idx(irq_idx)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EVT_SRC = 32'hF000_0000;

  typedef struct packed {
    logic [31:0] fire;
    logic [31:0] evt;
    logic        wen;
    logic [1:0]  adr;
    logic [31:0] wdat;
    logic [31:0] e_pend;
    logic [31:0] e_mask;
    logic        e_req;
    logic [4:0]  e_idx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0005, 32'h0, 1'b0, 2'd0, 32'h0,         32'h0000_0005, 32'h0,         1'b0, 5'd0},  // R2 R5
    '{32'h0,         32'h0, 1'b1, 2'd1, 32'h0000_0004, 32'h0000_0005, 32'h0000_0004, 1'b1, 5'd2},  // R9
    '{32'h0,         32'h0, 1'b1, 2'd1, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005, 1'b1, 5'd0},  // R7
    '{32'h0,         32'h0, 1'b1, 2'd0, 32'h0000_0001, 32'h0000_0004, 32'h0000_0005, 1'b1, 5'd2},  // R3
    '{32'h0,         32'h0, 1'b1, 2'd0, 32'h0,         32'h0000_0004, 32'h0000_0005, 1'b1, 5'd2},  // R3
    '{32'h0000_0004, 32'h0, 1'b1, 2'd0, 32'h0000_0004, 32'h0000_0004, 32'h0000_0005, 1'b1, 5'd2},  // R4
    '{32'h0,         32'h0, 1'b1, 2'd0, 32'h0000_0004, 32'h0,         32'h0000_0005, 1'b0, 5'd0},  // R3 R7
    '{32'h0, 32'h1000_0000, 1'b1, 2'd1, 32'h1000_0005, 32'h1000_0000, 32'h1000_0005, 1'b1, 5'd28}, // R8
    '{32'h0, 32'h1000_0000, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h1000_0000, 32'h1000_0005, 1'b1, 5'd28}, // R8
    '{32'h0,         32'h0, 1'b0, 2'd0, 32'h0,         32'h0,         32'h1000_0005, 1'b0, 5'd0},  // R8
    '{32'h8000_0001, 32'h0, 1'b0, 2'd0, 32'h0,         32'h0000_0001, 32'h1000_0005, 1'b1, 5'd0},  // R8 R2
    '{32'h0,         32'h0, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h1000_0005, 1'b1, 5'd0}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data, rd_data, src_fire, evt_backed, evt_summary;
  logic        irq_req;
  logic [4:0]  irq_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_fire(src_fire), .evt_backed(evt_backed),
    .evt_summary(evt_summary), .irq_req(irq_req), .irq_idx(irq_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req, input logic [31:0] ep, input logic [31:0] em,
                          input logic er, input logic [4:0] ei);
    addr = 2'd0; #1;
    chk({req, " pending"}, rd_data, ep);
    addr = 2'd1; #1;
    chk({req, " mask"}, rd_data, em);
    chk({req, " irq_req"}, {31'b0, irq_req}, {31'b0, er});
    chk({req, " irq_idx"}, {27'b0, irq_idx}, {27'b0, ei});
  endtask

  task automatic step(input logic [31:0] f, input logic w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    src_fire = f; wr_en = w; addr = a; wr_data = d;
    @(posedge clk); #1;
    src_fire = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0;
    src_fire = '0; evt_backed = EVT_SRC; evt_summary = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_all("R1 reset", 32'h0, 32'h0, 1'b0, 5'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      evt_summary = TBL[v].evt;
      step(TBL[v].fire, TBL[v].wen, TBL[v].adr, TBL[v].wdat);
      read_all($sformatf("vector %0d R2 R3 R4 R5 R7 R8 R9 R10", v),
               TBL[v].e_pend, TBL[v].e_mask, TBL[v].e_req, TBL[v].e_idx);
    end

    addr = 2'd3; #1;
    chk("R10 unmapped read", rd_data, 32'h0);

    step('0, 1'b1, 2'd1, 32'h0);
    read_all("R6 mask off drops request", 32'h1, 32'h0, 1'b0, 5'd0);
    step('0, 1'b1, 2'd1, 32'h1);
    read_all("R6 mask on delivers", 32'h1, 32'h1, 1'b1, 5'd0);

    step(32'h0000_0A00, 1'b1, 2'd1, 32'h0000_0E01);
    read_all("R7 R5 several pending", 32'h0000_0A01, 32'h0000_0E01, 1'b1, 5'd0);
    step('0, 1'b1, 2'd0, 32'h1);
    read_all("R7 next priority", 32'h0000_0A00, 32'h0000_0E01, 1'b1, 5'd9);

    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    read_all("R1 reset mid-run", 32'h0, 32'h0, 1'b0, 5'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule